// File: doc/BRIEF.md
# Timer Prescaler Clock Gate with Busy Handshake

This block controls the clock that drives a low-power timer's prescaler. A bus-side register holds a source select field, a clock enable bit and a timer enable bit. It also reports a busy flag and a write-error flag. The sources are per-cycle tick strobes that are synchronous to the timer clock. Source index 0 is a 1 kHz tick divided down from a 32 kHz oscillator. Source index 1 is a generic clock tick.

Every accepted change to the select or the enable is passed into the timer clock domain by a toggle request. The request crosses through a two-flop synchronizer. A toggle acknowledge comes back through two more flops. The busy flag stays high from the change until that acknowledge arrives, and software polls it before the next step. To enable the clock, software writes the select, waits for busy to clear, sets the enable with the select left unchanged, and waits again. To disable it, software clears the enable with the select unchanged and waits.

In the timer domain, the selected tick is gated by a registered enable. The result is the prescaler tick. It is suppressed while a debug halt is active, unless both the global run-in-debug bit and the timer's own debug bit are set.

Top module: `tmrclk_gate`

## Requirements
- R1: After reset, `rd_sel`=0, `rd_clk_en`=0, `busy`=0, `err`=0, `tmr_en`=0 and `tick_out`=0.
- R2: A clock-register write (`wr_clk`=1) made while busy is low that changes exactly one of select or enable stores the new value. `busy` reads 1 from the next bus cycle. A write that changes neither field leaves `busy` at 0.
- R3: `busy` returns to 0 within a bounded number of cycles after an accepted change. By the time it falls, the timer domain already uses the new select and enable.
- R4: A write that changes both select and enable while busy is low is ignored: the stored values and `busy` are unchanged, and `err` becomes 1. The next accepted write clears `err` to 0.
- R5: Clock-register writes made while `busy` is 1 are ignored and leave the stored select and enable unchanged.
- R6: A control write (`wr_ctl`=1) with `wr_tmr_en`=1 sets `tmr_en` only while the stored clock enable is 1 and busy is low. A control write with `wr_tmr_en`=0 always clears it.
- R7: `tick_out` equals, one timer clock later, the timer-domain enable ANDed with `src_tick[sel]` (index 0 = 1 kHz tick, index 1 = generic tick), and only when not frozen.
- R8: `frozen` = `dbg_halt` AND NOT (`dbg_run_all` AND `dbg_run_tmr`). While frozen, `tick_out` is 0 on the next timer clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register interface clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_tmr | input | 1 | Timer domain clock |
| rst_tmr | input | 1 | Synchronous active-high reset, timer domain |
| wr_clk | input | 1 | Write strobe for select and clock enable |
| wr_sel | input | SEL_W | Source select write data |
| wr_clk_en | input | 1 | Clock enable write data |
| wr_ctl | input | 1 | Write strobe for timer enable |
| wr_tmr_en | input | 1 | Timer enable write data |
| rd_sel | output | SEL_W | Stored source select |
| rd_clk_en | output | 1 | Stored clock enable |
| busy | output | 1 | Change in flight to the timer domain |
| err | output | 1 | Last clock write was a rejected double change |
| tmr_en | output | 1 | Timer enable bit |
| src_tick | input | N_SRC | Per-source tick strobes, timer domain |
| dbg_halt | input | 1 | Debug halt active |
| dbg_run_all | input | 1 | Global run-in-debug override |
| dbg_run_tmr | input | 1 | Timer's own debug override |
| tick_out | output | 1 | Gated prescaler tick |
| frozen | output | 1 | Prescaler and counter frozen |

## Verification
The assertions check the following on every cycle: the stored configuration holds while busy is high, a double-change write is rejected, the timer enable never rises without the clock enable, a frozen cycle is always followed by no tick, a tick only comes from an enabled gate, and the timer-domain configuration matches the register when busy falls. Some behaviour can only be shown by the bench's scenarios. These are the full enable and disable sequences, the choice of source under different tick patterns, a no-change write leaving busy low, and each combination of the debug overrides.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    localparam int TCG_N_SRC  = 2;
    localparam int TCG_SYNC_N = 2;

    typedef enum logic [1:0] {
        WR_NONE     = 2'd0,
        WR_APPLY    = 2'd1,
        WR_CONFLICT = 2'd2
    } wr_kind_e;

    function automatic wr_kind_e classify_write(input logic sel_chg, input logic en_chg);
        if (sel_chg && en_chg)      return WR_CONFLICT;
        else if (sel_chg || en_chg) return WR_APPLY;
        else                        return WR_NONE;
    endfunction

    function automatic logic freeze_f(input logic halt, input logic run_all, input logic run_tmr);
        return halt && !(run_all && run_tmr);
    endfunction

endpackage

// File: rtl/tcg_sync.sv
module tcg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= d;
                else chain[i] <= chain[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tcg_bus_regs.sv
module tcg_bus_regs
    import tcg_pkg::*;
#(
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_clk,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_clk_en,
    input  logic             wr_ctl,
    input  logic             wr_tmr_en,
    input  logic             ack_s,
    output logic [SEL_W-1:0] sel_q,
    output logic             en_q,
    output logic             req_tgl,
    output logic             busy,
    output logic             err,
    output logic             tmr_en
);
    wr_kind_e kind;

    assign busy = req_tgl ^ ack_s;
    assign kind = classify_write(wr_sel != sel_q, wr_clk_en != en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            en_q    <= 1'b0;
            req_tgl <= 1'b0;
            err     <= 1'b0;
            tmr_en  <= 1'b0;
        end else begin
            if (wr_clk && !busy) begin
                case (kind)
                    WR_CONFLICT: err <= 1'b1;
                    WR_APPLY: begin
                        err     <= 1'b0;
                        sel_q   <= wr_sel;
                        en_q    <= wr_clk_en;
                        req_tgl <= ~req_tgl;
                    end
                    default: err <= 1'b0;
                endcase
            end
            if (wr_ctl) begin
                if (!wr_tmr_en)          tmr_en <= 1'b0;
                else if (en_q && !busy)  tmr_en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tcg_tmr_side.sv
module tcg_tmr_side
    import tcg_pkg::*;
#(
    parameter int N_SRC = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_s,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             en_in,
    input  logic [N_SRC-1:0] src_tick,
    input  logic             dbg_halt,
    input  logic             dbg_run_all,
    input  logic             dbg_run_tmr,
    output logic             ack_tgl,
    output logic [SEL_W-1:0] sel_t,
    output logic             en_t,
    output logic             tick_out,
    output logic             frozen
);
    logic sel_tick;

    assign frozen   = freeze_f(dbg_halt, dbg_run_all, dbg_run_tmr);
    assign sel_tick = (int'(sel_t) < N_SRC) ? src_tick[sel_t] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_tgl  <= 1'b0;
            sel_t    <= '0;
            en_t     <= 1'b0;
            tick_out <= 1'b0;
        end else begin
            if (req_s != ack_tgl) begin
                sel_t   <= sel_in;
                en_t    <= en_in;
                ack_tgl <= req_s;
            end
            tick_out <= en_t && sel_tick && !frozen;
        end
    end
endmodule

// File: rtl/tmrclk_gate.sv
module tmrclk_gate
    import tcg_pkg::*;
#(
    parameter int N_SRC  = TCG_N_SRC,
    parameter int SYNC_N = TCG_SYNC_N,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk_bus,
    input  logic             rst_bus,
    input  logic             clk_tmr,
    input  logic             rst_tmr,
    input  logic             wr_clk,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_clk_en,
    input  logic             wr_ctl,
    input  logic             wr_tmr_en,
    output logic [SEL_W-1:0] rd_sel,
    output logic             rd_clk_en,
    output logic             busy,
    output logic             err,
    output logic             tmr_en,
    input  logic [N_SRC-1:0] src_tick,
    input  logic             dbg_halt,
    input  logic             dbg_run_all,
    input  logic             dbg_run_tmr,
    output logic             tick_out,
    output logic             frozen
);
    logic             req_tgl, req_s, ack_tgl, ack_s;
    logic [SEL_W-1:0] sel_t;
    logic             en_t;

    tcg_bus_regs #(.SEL_W(SEL_W)) u_regs (
        .clk(clk_bus), .rst(rst_bus),
        .wr_clk(wr_clk), .wr_sel(wr_sel), .wr_clk_en(wr_clk_en),
        .wr_ctl(wr_ctl), .wr_tmr_en(wr_tmr_en), .ack_s(ack_s),
        .sel_q(rd_sel), .en_q(rd_clk_en), .req_tgl(req_tgl),
        .busy(busy), .err(err), .tmr_en(tmr_en)
    );

    tcg_sync #(.STAGES(SYNC_N)) u_req_sync (
        .clk(clk_tmr), .rst(rst_tmr), .d(req_tgl), .q(req_s)
    );

    tcg_sync #(.STAGES(SYNC_N)) u_ack_sync (
        .clk(clk_bus), .rst(rst_bus), .d(ack_tgl), .q(ack_s)
    );

    tcg_tmr_side #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_tmr (
        .clk(clk_tmr), .rst(rst_tmr), .req_s(req_s),
        .sel_in(rd_sel), .en_in(rd_clk_en), .src_tick(src_tick),
        .dbg_halt(dbg_halt), .dbg_run_all(dbg_run_all), .dbg_run_tmr(dbg_run_tmr),
        .ack_tgl(ack_tgl), .sel_t(sel_t), .en_t(en_t),
        .tick_out(tick_out), .frozen(frozen)
    );
endmodule

// File: rtl/tcg_checker.sv
module tcg_checker #(
    parameter int SEL_W = 1
) (
    input logic             clk_bus,
    input logic             rst_bus,
    input logic             clk_tmr,
    input logic             rst_tmr,
    input logic             wr_clk,
    input logic [SEL_W-1:0] wr_sel,
    input logic             wr_clk_en,
    input logic [SEL_W-1:0] rd_sel,
    input logic             rd_clk_en,
    input logic             busy,
    input logic             err,
    input logic             tmr_en,
    input logic [SEL_W-1:0] sel_t,
    input logic             en_t,
    input logic             tick_out,
    input logic             frozen
);
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_bus) disable iff (rst_bus)
        busy |=> ($stable(rd_sel) && $stable(rd_clk_en))); // R5

    AST_DOUBLE_CHANGE_REJECTED: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (wr_clk && !busy && (wr_sel != rd_sel) && (wr_clk_en != rd_clk_en))
        |=> (err && $stable(rd_sel) && $stable(rd_clk_en))); // R4

    AST_TMR_EN_NEEDS_CLK: assert property (@(posedge clk_bus) disable iff (rst_bus)
        $rose(tmr_en) |-> $past(rd_clk_en)); // R6

    AST_APPLIED_AT_IDLE: assert property (@(posedge clk_bus) disable iff (rst_bus)
        $fell(busy) |-> ((sel_t == rd_sel) && (en_t == rd_clk_en))); // R3

    AST_FROZEN_NO_TICK: assert property (@(posedge clk_tmr) disable iff (rst_tmr)
        frozen |=> !tick_out); // R8

    AST_TICK_NEEDS_EN: assert property (@(posedge clk_tmr) disable iff (rst_tmr)
        tick_out |-> $past(en_t)); // R7
endmodule

bind tmrclk_gate tcg_checker #(.SEL_W(SEL_W)) u_chk (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_tmr(clk_tmr), .rst_tmr(rst_tmr),
    .wr_clk(wr_clk), .wr_sel(wr_sel), .wr_clk_en(wr_clk_en),
    .rd_sel(rd_sel), .rd_clk_en(rd_clk_en), .busy(busy), .err(err), .tmr_en(tmr_en),
    .sel_t(sel_t), .en_t(en_t), .tick_out(tick_out), .frozen(frozen)
);

// File: tb/tmrclk_gate_bench.sv
module tmrclk_gate_bench;
    logic clk_bus = 1'b0, clk_tmr = 1'b0;
    logic rst_bus, rst_tmr;
    logic wr_clk = 0, wr_clk_en = 0, wr_ctl = 0, wr_tmr_en = 0;
    logic [0:0] wr_sel = '0;
    logic [0:0] rd_sel;
    logic rd_clk_en, busy, err, tmr_en;
    logic [1:0] src_tick = '0;
    logic dbg_halt = 0, dbg_run_all = 0, dbg_run_tmr = 0;
    logic tick_out, frozen;

    int checks = 0, failures = 0;
    logic exp_q[$];
    string tag_q[$];
    logic m_en = 0;
    logic m_sel = 0;
    bit done = 0;

    always #2.5 clk_bus = ~clk_bus;
    always #6.5 clk_tmr = ~clk_tmr;

    tmrclk_gate u_tmrclk_gate (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_tmr(clk_tmr), .rst_tmr(rst_tmr),
        .wr_clk(wr_clk), .wr_sel(wr_sel), .wr_clk_en(wr_clk_en),
        .wr_ctl(wr_ctl), .wr_tmr_en(wr_tmr_en),
        .rd_sel(rd_sel), .rd_clk_en(rd_clk_en), .busy(busy), .err(err), .tmr_en(tmr_en),
        .src_tick(src_tick), .dbg_halt(dbg_halt), .dbg_run_all(dbg_run_all),
        .dbg_run_tmr(dbg_run_tmr), .tick_out(tick_out), .frozen(frozen)
    );

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic s, input logic e);
        @(negedge clk_bus);
        wr_clk = 1; wr_sel = s; wr_clk_en = e;
        @(negedge clk_bus);
        wr_clk = 0;
    endtask

    task automatic wr_tmr(input logic v);
        @(negedge clk_bus);
        wr_ctl = 1; wr_tmr_en = v;
        @(negedge clk_bus);
        wr_ctl = 0;
    endtask

    task automatic wait_idle(input string rq);
        int n = 0;
        while (busy && n < 60) begin
            @(negedge clk_bus);
            n++;
        end
        check(rq, int'(busy), 0);
    endtask

    // driver: one timer cycle of stimulus, expected tick pushed to the scoreboard
    task automatic drive(input string rq, input logic [1:0] t,
                         input logic h, input logic ga, input logic gt);
        logic fz;
        @(negedge clk_tmr);
        src_tick = t; dbg_halt = h; dbg_run_all = ga; dbg_run_tmr = gt;
        fz = h && !(ga && gt);
        exp_q.push_back(m_en && t[m_sel] && !fz);
        tag_q.push_back(rq);
        #1 check({rq, " frozen"}, int'(frozen), int'(fz));
    endtask

    task automatic drain;
        @(negedge clk_tmr);
        src_tick = '0; dbg_halt = 0;
        @(negedge clk_tmr);
    endtask

    // monitor: compare the registered tick one timer edge after each drive
    initial begin
        forever begin
            @(posedge clk_tmr);
            #1;
            if (exp_q.size() > 0) begin
                logic e;
                string rq;
                e = exp_q.pop_front();
                rq = tag_q.pop_front();
                check({rq, " tick_out"}, int'(tick_out), int'(e));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_bus = 1; rst_tmr = 1;
        repeat (4) @(negedge clk_tmr);
        rst_bus = 0; rst_tmr = 0;
        @(negedge clk_bus);
        check("R1 rd_sel", int'(rd_sel), 0);
        check("R1 rd_clk_en", int'(rd_clk_en), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 err", int'(err), 0);
        check("R1 tmr_en", int'(tmr_en), 0);
        check("R1 tick_out", int'(tick_out), 0);
        drive("R1", 2'b11, 0, 0, 0);
        drain();

        wr_tmr(1);
        check("R6 tmr_en blocked", int'(tmr_en), 0);

        wr_cfg(1, 0);
        check("R2 busy raised", int'(busy), 1);
        check("R2 rd_sel", int'(rd_sel), 1);
        wait_idle("R3 busy clears");
        m_sel = 1;

        wr_cfg(0, 1);
        check("R4 err", int'(err), 1);
        check("R4 sel kept", int'(rd_sel), 1);
        check("R4 en kept", int'(rd_clk_en), 0);
        check("R4 busy low", int'(busy), 0);

        wr_cfg(1, 1);
        check("R4 err cleared", int'(err), 0);
        check("R2 busy raised", int'(busy), 1);
        wr_cfg(0, 1);
        check("R5 sel kept", int'(rd_sel), 1);
        wait_idle("R3 busy clears");
        check("R5 sel after idle", int'(rd_sel), 1);
        m_en = 1;

        drive("R7", 2'b01, 0, 0, 0);
        drive("R7", 2'b10, 0, 0, 0);
        drive("R7", 2'b11, 0, 0, 0);
        drive("R7", 2'b00, 0, 0, 0);
        drive("R7", 2'b10, 0, 0, 0);
        drain();

        wr_cfg(1, 1);
        check("R2 no-change busy", int'(busy), 0);

        wr_tmr(1);
        check("R6 tmr_en set", int'(tmr_en), 1);
        wr_tmr(0);
        check("R6 tmr_en cleared", int'(tmr_en), 0);

        drive("R8", 2'b10, 1, 1, 0);
        drive("R8", 2'b10, 1, 0, 1);
        drive("R8", 2'b10, 1, 1, 1);
        drive("R8", 2'b10, 0, 0, 0);
        drive("R8", 2'b10, 1, 0, 0);
        drain();

        wr_cfg(0, 1);
        wait_idle("R3 busy clears");
        m_sel = 0;
        drive("R7", 2'b01, 0, 0, 0);
        drive("R7", 2'b10, 0, 0, 0);
        drain();

        wr_cfg(0, 0);
        check("R2 busy raised", int'(busy), 1);
        wait_idle("R3 busy clears");
        m_en = 0;
        drive("R7", 2'b11, 0, 0, 0);
        drain();
        repeat (3) @(negedge clk_tmr);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule